// File: doc/BRIEF.md
# Leveled Priority Interrupt Arbiter

This block gathers up to eighteen interrupt event lines and turns them into one request to the processor. Each line has a sticky pending flag, an enable bit and a three-bit urgency level. A flag records every event, even while its line is disabled. Among the lines that are both flagged and enabled, the one with the highest level wins. On equal levels, the lowest-numbered line wins.

The winner goes to the processor only when the processor's global interrupt enable is high and its current interrupt level is strictly below the winner's level. A line at level 0 can therefore never interrupt.

Software reaches the levels, enables and flags through a simple byte-wide register port:

- Level bytes sit at addresses 0..8. Each byte holds two lines: the even line in bits [2:0] and the odd line in bits [6:4].
- Enable bytes sit at 16..18 and hold eight lines each.
- Flag bytes sit at 24..26. They read back the flags, and writing 1 to a bit clears that flag.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A pulse on `evt_i[n]` sets flag n at the next clock edge whatever enable n holds; flag n reads back at address 24 + n/8, bit n%8.
- R2: Writing a byte to address 24 + k clears exactly the flags of lines 8k+b whose data bit b is 1; bits written as 0 leave their flags unchanged.
- R3: When an event and a clear for the same line fall in the same cycle, the flag ends up set.
- R4: Only a line whose flag and enable (address 16 + n/8, bit n%8) are both 1 can win; when no request is presented `irq_id_o` and `irq_lvl_o` read 0.
- R5: Among eligible lines the one with the numerically highest level wins.
- R6: Among eligible lines sharing the highest level, the lowest-numbered line wins.
- R7: `irq_req_o` is 0 whenever `cpu_ie_i` is 0, and flags are kept meanwhile.
- R8: A request is presented only when `cpu_il_i` is strictly less than the winner's level, so a level-0 line is never presented.
- R9: Level byte at address n/2 holds line n in bits [2:0] for even n and in bits [6:4] for odd n; bits 3 and 7 read 0.
- R10: `irq_req_o`, `irq_id_o` and `irq_lvl_o` are registered and change one clock after the flag, enable, level, `cpu_ie_i` or `cpu_il_i` change that causes them.
- R11: After synchronous reset all flags, enables and levels are 0 and no request is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 18 | One-cycle event pulses, one per line |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 5 | Register read address |
| rd_data_o | output | 8 | Combinational read data |
| cpu_ie_i | input | 1 | Processor global interrupt enable |
| cpu_il_i | input | 3 | Processor current interrupt level |
| irq_req_o | output | 1 | Request to the processor |
| irq_id_o | output | 5 | Winning line number |
| irq_lvl_o | output | 3 | Winning line's level |

## Verification
Two things can land on one flag in the same edge: a fresh event on a line and a write-1 clear of that line's flag. The bench provokes this by raising the event bit and strobing the clear write in the same cycle. It then judges the outcome twice: the flag byte must read the bit as set, and the request must name that line with its level on the following cycle. A second collision, between a lower-numbered and a higher-numbered line at equal level, is judged by the winning ID.

// File: rtl/prio_irq_pkg.sv
// Package: shared constants for the leveled priority interrupt arbiter.
// Assumes byte-wide registers and a fixed three-bit urgency level.
package prio_irq_pkg;
    localparam int LVL_W  = 3;   // width of one urgency level
    localparam int REG_W  = 8;   // register port data width
    localparam int SLOT_W = 4;   // bit stride between two levels in one byte
    localparam int PER_LVL_REG = REG_W / SLOT_W;  // lines per level byte

    // Region of the register map an address falls in
    typedef enum logic [1:0] {
        RG_LVL  = 2'd0,
        RG_ENA  = 2'd1,
        RG_FLG  = 2'd2,
        RG_NONE = 2'd3
    } region_e;
endpackage

// File: rtl/prio_irq_regs.sv
// Module: level and enable register file with byte-wide write and read.
// Decodes write-1-to-clear strobes for the flag bytes and muxes read data.
// Assumes one write per cycle; reads are combinational and side-effect free.
module prio_irq_regs
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC  = 18,
    parameter int ADDR_W   = 5,
    parameter int LVL_BASE = 0,
    parameter int ENA_BASE = 16,
    parameter int FLG_BASE = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [REG_W-1:0]              wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [NUM_SRC-1:0]            flag_q,
    output logic [NUM_SRC-1:0]            ena_q,
    output logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q,
    output logic [NUM_SRC-1:0]            clr_mask,
    output logic [REG_W-1:0]              rd_data
);
    localparam int LVL_REGS = (NUM_SRC + PER_LVL_REG - 1) / PER_LVL_REG;
    localparam int BIT_REGS = (NUM_SRC + REG_W - 1) / REG_W;

    // Classify an address into a register region and return its index
    function automatic region_e classify(input logic [ADDR_W-1:0] a, output int idx);
        int ai;
        ai  = int'(a);
        idx = 0;
        if (ai >= LVL_BASE && ai < LVL_BASE + LVL_REGS) begin
            idx = ai - LVL_BASE;
            return RG_LVL;
        end
        if (ai >= ENA_BASE && ai < ENA_BASE + BIT_REGS) begin
            idx = ai - ENA_BASE;
            return RG_ENA;
        end
        if (ai >= FLG_BASE && ai < FLG_BASE + BIT_REGS) begin
            idx = ai - FLG_BASE;
            return RG_FLG;
        end
        return RG_NONE;
    endfunction

    region_e wr_rg;
    int      wr_idx;
    region_e rd_rg;
    int      rd_idx;

    // Decode the write address once per cycle
    always_comb begin
        wr_rg = classify(wr_addr, wr_idx);
    end

    // Update level and enable registers on writes to their bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q <= '0;
            lvl_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (wr_rg == RG_LVL && wr_idx == i / PER_LVL_REG)
                    lvl_q[i] <= wr_data[(i % PER_LVL_REG) * SLOT_W +: LVL_W];
                if (wr_rg == RG_ENA && wr_idx == i / REG_W)
                    ena_q[i] <= wr_data[i % REG_W];
            end
        end
    end

    // Form the per-line clear strobes from writes to flag bytes
    always_comb begin
        clr_mask = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            clr_mask[i] = wr_en && wr_rg == RG_FLG && wr_idx == i / REG_W
                          && wr_data[i % REG_W];
        end
    end

    // Assemble the read byte for the addressed register
    always_comb begin
        rd_rg   = classify(rd_addr, rd_idx);
        rd_data = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (rd_rg == RG_LVL && rd_idx == i / PER_LVL_REG)
                rd_data[(i % PER_LVL_REG) * SLOT_W +: LVL_W] = lvl_q[i];
            if (rd_rg == RG_ENA && rd_idx == i / REG_W)
                rd_data[i % REG_W] = ena_q[i];
            if (rd_rg == RG_FLG && rd_idx == i / REG_W)
                rd_data[i % REG_W] = flag_q[i];
        end
    end
endmodule

// File: rtl/prio_irq_flags.sv
// Module: sticky pending flags, one per line.
// A flag is set by an event pulse and cleared by its clear strobe.
// When both arrive in the same cycle the set takes precedence.
// Assumes events are synchronous to clk.
module prio_irq_flags #(
    parameter int NUM_SRC = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] flag_q
);
    // Hold each flag until cleared; a new event overrides a clear
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_mask) | evt;
    end
endmodule

// File: rtl/prio_irq_pick.sv
// Module: combinational winner selection among eligible lines.
// Highest level wins; on equal levels the lowest index wins.
// Assumes NUM_SRC >= 2 so that ID_W is at least one bit.
module prio_irq_pick
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 18,
    parameter int ID_W    = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]            elig,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
    output logic                          found,
    output logic [ID_W-1:0]               win_id,
    output logic [LVL_W-1:0]              win_lvl
);
    // Scan from the top index down so a lower index replaces a tie
    always_comb begin
        found   = 1'b0;
        win_id  = '0;
        win_lvl = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i] && (!found || lvl[i] >= win_lvl)) begin
                found   = 1'b1;
                win_id  = ID_W'(i);
                win_lvl = lvl[i];
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: top of the leveled priority interrupt arbiter.
// Combines flags, enables and levels, picks a winner and gates it against
// the processor's global enable and current level. Outputs are registered.
// Assumes all inputs are synchronous to clk.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC  = 18,
    parameter int ADDR_W   = 5,
    parameter int LVL_BASE = 0,
    parameter int ENA_BASE = 16,
    parameter int FLG_BASE = 24,
    localparam int ID_W    = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [REG_W-1:0]   wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [REG_W-1:0]   rd_data_o,
    input  logic               cpu_ie_i,
    input  logic [LVL_W-1:0]   cpu_il_i,
    output logic               irq_req_o,
    output logic [ID_W-1:0]    irq_id_o,
    output logic [LVL_W-1:0]   irq_lvl_o
);
    logic [NUM_SRC-1:0]            flag_q;
    logic [NUM_SRC-1:0]            ena_q;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;
    logic [NUM_SRC-1:0]            clr_mask;
    logic                          found;
    logic [ID_W-1:0]               win_id;
    logic [LVL_W-1:0]              win_lvl;
    logic                          accept;

    prio_irq_regs #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .LVL_BASE(LVL_BASE),
        .ENA_BASE(ENA_BASE),
        .FLG_BASE(FLG_BASE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .wr_data (wr_data_i),
        .rd_addr (rd_addr_i),
        .flag_q  (flag_q),
        .ena_q   (ena_q),
        .lvl_q   (lvl_q),
        .clr_mask(clr_mask),
        .rd_data (rd_data_o)
    );

    prio_irq_flags #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_i),
        .clr_mask(clr_mask),
        .flag_q  (flag_q)
    );

    prio_irq_pick #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_pick (
        .elig   (flag_q & ena_q),
        .lvl    (lvl_q),
        .found  (found),
        .win_id (win_id),
        .win_lvl(win_lvl)
    );

    // Gate the winner by the processor's enable and strict level compare
    always_comb begin
        accept = found && cpu_ie_i && (cpu_il_i < win_lvl);
    end

    // Register the request; ID and level read zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req_o <= 1'b0;
            irq_id_o  <= '0;
            irq_lvl_o <= '0;
        end else begin
            irq_req_o <= accept;
            irq_id_o  <= accept ? win_id  : '0;
            irq_lvl_o <= accept ? win_lvl : '0;
        end
    end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
// Module: assertion checker bound to prio_irq_ctrl.
// Watches the request outputs against the processor-side gating inputs
// and the internal flag and enable state.
module prio_irq_ctrl_chk
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 18,
    parameter int ID_W    = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               cpu_ie_i,
    input logic [LVL_W-1:0]   cpu_il_i,
    input logic               irq_req_o,
    input logic [ID_W-1:0]    irq_id_o,
    input logic [LVL_W-1:0]   irq_lvl_o,
    input logic [NUM_SRC-1:0] flag_q,
    input logic [NUM_SRC-1:0] ena_q
);
    logic [NUM_SRC-1:0] elig_d;

    // Keep last cycle's eligible set to compare with the registered winner
    always_ff @(posedge clk) begin
        if (!rst_n) elig_d <= '0;
        else        elig_d <= flag_q & ena_q;
    end

    // R4
    winner_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> elig_d[irq_id_o]);

    // R7
    ie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> $past(cpu_ie_i));

    // R8
    il_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> ($past(cpu_il_i) < irq_lvl_o));

    // R8
    lvl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> irq_lvl_o != '0);

    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !irq_req_o);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .cpu_ie_i (cpu_ie_i),
    .cpu_il_i (cpu_il_i),
    .irq_req_o(irq_req_o),
    .irq_id_o (irq_id_o),
    .irq_lvl_o(irq_lvl_o),
    .flag_q   (flag_q),
    .ena_q    (ena_q)
);

// File: tb/test_prio_irq_ctrl.sv
// Scoreboard bench: driver tasks queue expected request outputs, a monitor
// pops and compares them one time unit after each falling edge.
module test_prio_irq_ctrl;
    localparam int N = 18;

    typedef struct {
        bit    req;
        int    id;
        int    lvl;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt = '0;
    logic         wr_en = 1'b0;
    logic [4:0]   wr_addr = '0;
    logic [7:0]   wr_data = '0;
    logic [4:0]   rd_addr = '0;
    logic [7:0]   rd_data;
    logic         cpu_ie = 1'b0;
    logic [2:0]   cpu_il = '0;
    logic         irq_req;
    logic [4:0]   irq_id;
    logic [2:0]   irq_lvl;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    always #4 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .cpu_ie_i(cpu_ie), .cpu_il_i(cpu_il),
        .irq_req_o(irq_req), .irq_id_o(irq_id), .irq_lvl_o(irq_lvl)
    );

    // Monitor: compare queued expectations with the outputs
    always begin
        @(negedge clk);
        #1;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (irq_req !== e.req || int'(irq_id) != e.id || int'(irq_lvl) != e.lvl) begin
                n_bad++;
                $display("FAIL %s: got req=%0b id=%0d lvl=%0d, expected req=%0b id=%0d lvl=%0d",
                         e.tag, irq_req, irq_id, irq_lvl, e.req, e.id, e.lvl);
            end
        end
    end

    // Queue an expectation for the outputs as they stand now
    task automatic expect_now(input bit r, input int id, input int lv, input string tag);
        exp_t e;
        e.req = r; e.id = id; e.lvl = lv; e.tag = tag;
        q.push_back(e);
    endtask

    // Queue an expectation after one more clock edge has registered outputs
    task automatic expect_irq(input bit r, input int id, input int lv, input string tag);
        @(negedge clk);
        expect_now(r, id, lv, tag);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(negedge clk);
        evt = m;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic check_reg(input int a, input int exp_v, input string tag);
        rd_addr = 5'(a);
        #1;
        n_chk++;
        if (int'(rd_data) != exp_v) begin
            n_bad++;
            $display("FAIL %s: addr %0d got 0x%02h expected 0x%02h", tag, a, rd_data, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_irq(0, 0, 0, "R11 idle after reset");
        check_reg(0, 8'h00, "R11 level byte");
        check_reg(16, 8'h00, "R11 enable byte");
        check_reg(24, 8'h00, "R11 flag byte");

        cpu_ie = 1'b1;
        pulse(N'(1) << 3);
        check_reg(24, 8'h08, "R1 flag set while disabled");
        expect_irq(0, 0, 0, "R4 disabled line silent");

        wr(1, 8'h50);
        check_reg(1, 8'h50, "R9 odd slot");
        wr(2, 8'hFF);
        check_reg(2, 8'h77, "R9 bits 3 and 7 read 0");
        wr(16, 8'h08);
        expect_now(0, 0, 0, "R10 no change before output edge");
        expect_irq(1, 3, 5, "R4 enabled flagged line");

        wr(5, 8'h06);
        wr(17, 8'h04);
        pulse((N'(1) << 10) | (N'(1) << 4));
        expect_irq(1, 10, 6, "R5 higher level wins, disabled level 7 ignored");
        check_reg(24, 8'h18, "R1 flags 3 and 4");

        wr(0, 8'h60);
        wr(16, 8'h0A);
        pulse(N'(1) << 1);
        expect_irq(1, 1, 6, "R6 tie to lowest index");

        cpu_il = 3'd6;
        expect_irq(0, 0, 0, "R8 equal level blocked");
        cpu_il = 3'd5;
        expect_irq(1, 1, 6, "R8 lower current level passes");
        wr(24, 8'h02);
        expect_irq(1, 10, 6, "R2 cleared line drops out");
        wr(25, 8'h04);
        expect_irq(0, 0, 0, "R8 level 5 vs current 5");
        cpu_il = 3'd4;
        expect_irq(1, 3, 5, "R8 level 5 vs current 4");

        cpu_ie = 1'b0;
        expect_now(1, 3, 5, "R10 IE change waits one edge");
        expect_irq(0, 0, 0, "R7 global enable off");
        check_reg(24, 8'h18, "R7 flags kept while IE off");
        cpu_ie = 1'b1;
        expect_irq(1, 3, 5, "R7 global enable back on");

        wr(24, 8'h00);
        check_reg(24, 8'h18, "R2 zero write keeps flags");
        expect_irq(1, 3, 5, "R2 zero write keeps request");
        wr(24, 8'h18);
        check_reg(24, 8'h00, "R2 ones clear flags");
        expect_irq(0, 0, 0, "R2 request gone after clear");

        @(negedge clk);
        evt = N'(1) << 3;
        wr_en = 1'b1; wr_addr = 5'd24; wr_data = 8'h08;
        @(negedge clk);
        evt = '0; wr_en = 1'b0;
        check_reg(24, 8'h08, "R3 set beats clear");
        expect_irq(1, 3, 5, "R3 request after collision");

        wr(24, 8'h08);
        wr(18, 8'h02);
        cpu_il = 3'd0;
        pulse(N'(1) << 17);
        check_reg(26, 8'h02, "R1 flag of line 17");
        expect_irq(0, 0, 0, "R8 level 0 never presented");
        wr(8, 8'h30);
        expect_irq(1, 17, 3, "R9 odd slot level for line 17");

        @(negedge clk);
        #2;
        done = 1;
        finish_run();
    end
endmodule